// File: doc/BRIEF.md
# Immediate-Capable Integer ALU

This block is the purely combinational integer datapath of a simple 32-bit processor. It computes one result per operation code: addition and subtraction that wrap, the bitwise AND, OR, XOR and NOR, a signed set-less-than, and a load-upper operation.

Operand A is always the first register operand. Operand B is either the second register operand or the 16-bit immediate widened to 32 bits. A select bit chooses between the two. A separate flag chooses sign extension or zero extension for the immediate.

The instruction decoder ahead of this block sets the extension flag according to the instruction:
- sign extension for immediate add and immediate set-less-than;
- zero extension for immediate AND, OR and XOR.

A zero flag accompanies every result. The block holds no state and has no clock.

Top module: `imm_alu`

Operation code values on `op_i`: 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR, 5 NOR, 6 set-less-than, 7 load-upper.

## Requirements
- R1: With op_i = 0, result_o equals A + B modulo 2^32; a carry out of bit 31 is dropped and no other output reacts to it.
- R2: With op_i = 1, result_o equals A − B modulo 2^32, so 0 − 1 gives 0xFFFFFFFF.
- R3: With op_i = 2, 3 and 4, result_o is the bitwise AND, OR and XOR of A and B respectively.
- R4: With op_i = 5, result_o is the bitwise complement of (A OR B); with A = B = 0 it is 0xFFFFFFFF.
- R5: With op_i = 6, result_o is 1 when A is less than B as signed two's-complement numbers and 0 otherwise. Bits 31:1 are always zero. The answer is correct when A − B overflows, for example 0x7FFFFFFF against 0x80000000 gives 0.
- R6: When use_imm_i = 1 and ext_signed_i = 1, B is the immediate with bit 15 copied into bits 31:16, covering −32768 to 32767.
- R7: When use_imm_i = 1 and ext_signed_i = 0, B is the immediate with bits 31:16 cleared, covering 0x0000 to 0xFFFF.
- R8: With op_i = 7, result_o is imm_i in bits 31:16 and zeros in bits 15:0. It does not depend on A, on b_i, on use_imm_i or on ext_signed_i.
- R9: When use_imm_i = 0, B equals b_i, and imm_i and ext_signed_i have no effect on result_o for op_i values 0 to 6.
- R10: zero_o is 1 exactly when result_o is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | Operand A (first register operand) |
| b_i | input | 32 | Second register operand |
| imm_i | input | 16 | Immediate field |
| use_imm_i | input | 1 | 1: operand B is the extended immediate; 0: operand B is b_i |
| ext_signed_i | input | 1 | 1: sign-extend the immediate; 0: zero-extend it |
| op_i | input | 3 | Operation code (0 add, 1 sub, 2 and, 3 or, 4 xor, 5 nor, 6 slt, 7 lui) |
| result_o | output | 32 | Operation result |
| zero_o | output | 1 | High when result_o is zero |

## Verification
The hardest case to reach is a signed comparison whose internal subtraction overflows. There, the sign of the difference gives the wrong answer, and only the operand signs give the right one.

The stimulus forces this case directly. It pairs the largest positive value with the most negative value in both orders. It also compares the most negative value with a small positive number.

A further directed case feeds a negative sign-extended immediate into the comparison. This exercises the extension path and the signed compare together.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4,
    OP_NOR = 3'd5,
    OP_SLT = 3'd6,
    OP_LUI = 3'd7
  } alu_op_e;

  // Signed less-than from the operand signs and the sign of (a - b).
  // When the signs differ the subtraction may overflow, so the sign of a decides.
  function automatic logic signed_less(input logic sign_a, input logic sign_b,
                                       input logic diff_sign);
    if (sign_a != sign_b) return sign_a;
    return diff_sign;
  endfunction

  // Operation needs the adder in subtract mode.
  function automatic logic needs_subtract(input alu_op_e op);
    return (op == OP_SUB) || (op == OP_SLT);
  endfunction

endpackage

// File: rtl/alu_operand_b.sv
module alu_operand_b
  import alu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int IMM_W = 16
) (
  input  logic [WIDTH-1:0] reg_b,
  input  logic [IMM_W-1:0] imm,
  input  logic             use_imm,
  input  logic             ext_signed,
  output logic [WIDTH-1:0] opnd_b
);
  localparam int UPPER_W = WIDTH - IMM_W;

  logic [UPPER_W-1:0] upper_fill;
  logic [WIDTH-1:0]   imm_wide;

  assign upper_fill = ext_signed ? {UPPER_W{imm[IMM_W-1]}} : {UPPER_W{1'b0}};
  assign imm_wide   = {upper_fill, imm};
  assign opnd_b     = use_imm ? imm_wide : reg_b;

  always_comb begin
    if (use_imm && ext_signed) begin
      a_r6_sign_ext: assert ((opnd_b[WIDTH-1:IMM_W] == '0) || (opnd_b[WIDTH-1:IMM_W] == '1))
        else $error("upper half of sign-extended operand is not uniform");
    end
    if (use_imm && !ext_signed) begin
      a_r7_zero_ext: assert (opnd_b[WIDTH-1:IMM_W] == '0)
        else $error("zero-extended operand has upper bits set");
    end
  end

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  alu_op_e          op,
  output logic [WIDTH-1:0] sum,
  output logic             less
);
  logic             sub_en;
  logic [WIDTH-1:0] b_adj;

  assign sub_en = needs_subtract(op);
  assign b_adj  = sub_en ? ~opnd_b : opnd_b;
  assign sum    = opnd_a + b_adj + {{(WIDTH-1){1'b0}}, sub_en};
  assign less   = signed_less(opnd_a[WIDTH-1], opnd_b[WIDTH-1], sum[WIDTH-1]);

  always_comb begin
    if (op == OP_SUB) begin
      a_r2_sub_inverse: assert (sum + opnd_b == opnd_a)
        else $error("difference plus subtrahend does not restore minuend");
    end
    if (op == OP_ADD) begin
      a_r1_add_inverse: assert (sum - opnd_b == opnd_a)
        else $error("sum minus addend does not restore augend");
    end
  end

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int IMM_W = 16
) (
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic [IMM_W-1:0] imm,
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] arith_sum,
  input  logic             arith_less,
  output logic [WIDTH-1:0] result
);
  localparam int LOW_W = WIDTH - IMM_W;

  logic [WIDTH-1:0] or_val;
  logic [WIDTH-1:0] lui_val;

  assign or_val  = opnd_a | opnd_b;
  assign lui_val = {imm, {LOW_W{1'b0}}};

  always_comb begin
    unique case (op)
      OP_ADD, OP_SUB: result = arith_sum;
      OP_AND:         result = opnd_a & opnd_b;
      OP_OR:          result = or_val;
      OP_XOR:         result = opnd_a ^ opnd_b;
      OP_NOR:         result = ~or_val;
      OP_SLT:         result = {{(WIDTH-1){1'b0}}, arith_less};
      OP_LUI:         result = lui_val;
      default:        result = '0;
    endcase
  end

  always_comb begin
    if (op == OP_SLT) begin
      a_r5_slt_range: assert (result[WIDTH-1:1] == '0)
        else $error("set-less-than result wider than one bit");
    end
    if (op == OP_NOR) begin
      a_r4_nor_disjoint: assert (((result & (opnd_a | opnd_b)) == '0) &&
                                 ((result | opnd_a | opnd_b) == '1))
        else $error("nor result not the complement of the or");
    end
    if (op == OP_LUI) begin
      a_r8_lui_low: assert (result[LOW_W-1:0] == '0)
        else $error("load-upper low half not cleared");
    end
  end

endmodule

// File: rtl/imm_alu.sv
module imm_alu
  import alu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int IMM_W = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             use_imm_i,
  input  logic             ext_signed_i,
  input  logic [2:0]       op_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o
);
  alu_op_e          op;
  logic [WIDTH-1:0] opnd_b;
  logic [WIDTH-1:0] arith_sum;
  logic             arith_less;

  assign op = alu_op_e'(op_i);

  alu_operand_b #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_opb (
    .reg_b      (b_i),
    .imm        (imm_i),
    .use_imm    (use_imm_i),
    .ext_signed (ext_signed_i),
    .opnd_b     (opnd_b)
  );

  alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .opnd_a (a_i),
    .opnd_b (opnd_b),
    .op     (op),
    .sum    (arith_sum),
    .less   (arith_less)
  );

  alu_core #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_core (
    .opnd_a     (a_i),
    .opnd_b     (opnd_b),
    .imm        (imm_i),
    .op         (op),
    .arith_sum  (arith_sum),
    .arith_less (arith_less),
    .result     (result_o)
  );

  assign zero_o = (result_o == '0);

  always_comb begin
    if (zero_o) begin
      a_r10_zero_flag: assert ($countones(result_o) == 0)
        else $error("zero flag set with nonzero result");
    end
  end

endmodule

// File: tb/imm_alu_test.sv
module imm_alu_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] a, b;
  logic [15:0] imm;
  logic        use_imm, sgn;
  logic [2:0]  op;
  logic [31:0] res;
  logic        zf;
  int          n_checks = 0;
  int          n_err = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  imm_alu uut (
    .a_i(a), .b_i(b), .imm_i(imm), .use_imm_i(use_imm),
    .ext_signed_i(sgn), .op_i(op), .result_o(res), .zero_o(zf)
  );

  task automatic apply(input logic [2:0] o, input logic [31:0] av, input logic [31:0] bv,
                       input logic [15:0] iv, input logic ui, input logic si);
    @(negedge clk);
    op = o; a = av; b = bv; imm = iv; use_imm = ui; sgn = si;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] exp);
    n_checks++;
    if (res !== exp) begin
      n_err++;
      $display("FAIL %s result: actual %h expected %h", req, res, exp);
    end
    n_checks++;
    if (zf !== (exp == 32'h0)) begin
      n_err++;
      $display("FAIL R10 zero flag (%s): actual %b expected %b", req, zf, exp == 32'h0);
    end
  endtask

  task automatic t_reset;
    apply(3'd0, 32'h0, 32'h0, 16'h0, 1'b0, 1'b0);
    check("R10 idle", 32'h0);
  endtask

  task automatic t_add;
    apply(3'd0, 32'd7, 32'd5, 16'h0, 1'b0, 1'b0);          check("R1", 32'd12);
    apply(3'd0, 32'hFFFF_FFFF, 32'd1, 16'h0, 1'b0, 1'b0);  check("R1 wrap", 32'h0);
    apply(3'd0, 32'h8000_0000, 32'h8000_0001, 16'h0, 1'b0, 1'b0); check("R1 wrap2", 32'h1);
  endtask

  task automatic t_sub;
    apply(3'd1, 32'd0, 32'd1, 16'h0, 1'b0, 1'b0);          check("R2 wrap", 32'hFFFF_FFFF);
    apply(3'd1, 32'd5, 32'd5, 16'h0, 1'b0, 1'b0);          check("R2 equal", 32'h0);
    apply(3'd1, 32'd100, 32'd58, 16'h0, 1'b0, 1'b0);       check("R2", 32'd42);
  endtask

  task automatic t_logic;
    apply(3'd2, 32'hF0F0_1234, 32'h0FF0_FF00, 16'h0, 1'b0, 1'b0); check("R3 and", 32'h00F0_1200);
    apply(3'd3, 32'hF0F0_1234, 32'h0FF0_FF00, 16'h0, 1'b0, 1'b0); check("R3 or",  32'hFFF0_FF34);
    apply(3'd4, 32'hF0F0_1234, 32'h0FF0_FF00, 16'h0, 1'b0, 1'b0); check("R3 xor", 32'hFF00_ED34);
    apply(3'd4, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 16'h0, 1'b0, 1'b0); check("R3 xor self", 32'h0);
  endtask

  task automatic t_nor;
    apply(3'd5, 32'h0, 32'h0, 16'h0, 1'b0, 1'b0);                 check("R4 zeros", 32'hFFFF_FFFF);
    apply(3'd5, 32'hF000_000F, 32'h0000_FF00, 16'h0, 1'b0, 1'b0); check("R4", 32'h0FFF_00F0);
    apply(3'd5, 32'hFFFF_0000, 32'h0000_FFFF, 16'h0, 1'b0, 1'b0); check("R4 all", 32'h0);
  endtask

  task automatic t_slt;
    apply(3'd6, 32'hFFFF_FFFF, 32'd1, 16'h0, 1'b0, 1'b0);         check("R5 neg<pos", 32'd1);
    apply(3'd6, 32'd1, 32'hFFFF_FFFF, 16'h0, 1'b0, 1'b0);         check("R5 pos<neg", 32'd0);
    apply(3'd6, 32'h7FFF_FFFF, 32'h8000_0000, 16'h0, 1'b0, 1'b0); check("R5 ovf max<min", 32'd0);
    apply(3'd6, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0, 1'b0, 1'b0); check("R5 ovf min<max", 32'd1);
    apply(3'd6, 32'h8000_0000, 32'd1, 16'h0, 1'b0, 1'b0);         check("R5 min<1", 32'd1);
    apply(3'd6, 32'd9, 32'd9, 16'h0, 1'b0, 1'b0);                 check("R5 equal", 32'd0);
    apply(3'd6, 32'd3, 32'd9, 16'h0, 1'b0, 1'b0);                 check("R5 small", 32'd1);
  endtask

  task automatic t_sign_imm;
    apply(3'd0, 32'd10, 32'h0, 16'hFFFF, 1'b1, 1'b1);             check("R6 addi -1", 32'd9);
    apply(3'd0, 32'd0, 32'h0, 16'h8000, 1'b1, 1'b1);              check("R6 addi min", 32'hFFFF_8000);
    apply(3'd0, 32'd0, 32'h0, 16'h7FFF, 1'b1, 1'b1);              check("R6 addi max", 32'h0000_7FFF);
    apply(3'd6, 32'hFFFF_FFF0, 32'h0, 16'h8000, 1'b1, 1'b1);      check("R6 slti -16<-32768", 32'd0);
    apply(3'd6, 32'hFFFF_8001, 32'h0, 16'hFFFF, 1'b1, 1'b1);      check("R6 slti neg<-1", 32'd1);
  endtask

  task automatic t_zero_imm;
    apply(3'd3, 32'h0, 32'h0, 16'h8001, 1'b1, 1'b0);              check("R7 ori", 32'h0000_8001);
    apply(3'd2, 32'hFFFF_FFFF, 32'h0, 16'hFFFF, 1'b1, 1'b0);      check("R7 andi", 32'h0000_FFFF);
    apply(3'd4, 32'h1234_5678, 32'h0, 16'h00FF, 1'b1, 1'b0);      check("R7 xori", 32'h1234_5687);
  endtask

  task automatic t_lui;
    apply(3'd7, 32'hAAAA_5555, 32'h1357_9BDF, 16'h2110, 1'b0, 1'b0); check("R8 lui", 32'h2110_0000);
    apply(3'd7, 32'h1111_1111, 32'h2222_2222, 16'hF00D, 1'b1, 1'b1); check("R8 lui sgn", 32'hF00D_0000);
    apply(3'd7, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h0000, 1'b1, 1'b0); check("R8 lui zero", 32'h0);
  endtask

  task automatic t_reg_select;
    apply(3'd0, 32'd1000, 32'd24, 16'hFFFF, 1'b0, 1'b1);          check("R9 add ignores imm", 32'd1024);
    apply(3'd0, 32'd1000, 32'd24, 16'h1234, 1'b0, 1'b0);          check("R9 add ignores imm2", 32'd1024);
    apply(3'd6, 32'd5, 32'hFFFF_FFFB, 16'h7FFF, 1'b0, 1'b1);      check("R9 slt uses b", 32'd0);
    apply(3'd2, 32'hFFFF_FFFF, 32'hA5A5_0000, 16'hFFFF, 1'b0, 1'b0); check("R9 and uses b", 32'hA5A5_0000);
  endtask

  initial begin
    op = 3'd0; a = '0; b = '0; imm = '0; use_imm = 1'b0; sgn = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset();
    t_add();
    t_sub();
    t_logic();
    t_nor();
    t_slt();
    t_sign_imm();
    t_zero_imm();
    t_lui();
    t_reg_select();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

endmodule